// File: doc/BRIEF.md
# Cycle-Stealing Buffered Transfer Engine

This engine moves single words between eight peripheral channels and main memory. It takes its memory cycles from the processor by holding the processor off its next instruction. Channels 0 to 3 carry input, which is written to memory. Channels 4 to 7 carry output, which is read from memory and handed to the peripheral. Each channel is governed by two control words: a remaining word count and the address of the next data word. A static configuration places each control word either in one of four on-chip fast registers or in main memory. For channel n, the in-memory copies sit at `CW_BASE + 2n` (count) and `CW_BASE + 2n + 1` (address).

Software first stores the in-memory control words itself. It then issues an activate command, which also loads any fast control words for that channel, and the peripheral starts raising its request line. Every granted request runs a short sequence. The engine decrements the count and increments the address, using memory only for the words that are not held on chip. It then performs the data cycle at the address held before the increment. The transfer in which the count reaches zero still completes. That same transfer deactivates the channel and sets a completion interrupt, which a lockout flag can mask.

The sequencer has four states. `ST_IDLE` arbitrates. `ST_CNT` is the read/decrement/write-back cycle on an in-memory count. `ST_ADR` is the read/increment/write-back cycle on an in-memory address. `ST_DAT` is the data cycle. The transitions are as follows. `ST_IDLE` goes to `ST_CNT` on a grant whose count is in memory. Otherwise it goes to `ST_ADR` if the address is in memory, and otherwise straight to `ST_DAT`. `ST_CNT` goes to `ST_ADR` or `ST_DAT` by the same address rule. `ST_ADR` always goes to `ST_DAT`. `ST_DAT` always returns to `ST_IDLE`.

Top module: `bufio_steal`

## Requirements
- R1: After reset, `stall`, `ack`, `irq` and `mem_req` are all zero and no channel is active.
- R2: A channel with both control words in memory stalls the processor for exactly 3 cycles per word. Its in-memory count is written back one lower and its in-memory address one higher.
- R3: A channel with exactly one control word in memory stalls for exactly 2 cycles per word, and the in-memory word is still updated.
- R4: A channel with both control words in fast registers stalls for exactly 1 cycle per word.
- R5: An input channel's word is written to memory at the address held before the increment, so successive words land at consecutive addresses.
- R6: For an output channel, the memory word at the pre-increment address is driven on `out_data` in the same cycle that the channel's `ack` bit is high.
- R7: The transfer that brings the count to zero still moves its word, deactivates the channel so later requests get no `ack`, and sets `irq` for that channel. Re-activating the channel clears its interrupt.
- R8: While `lockout` is 1, every `irq` bit reads 0. A completion that happened under lockout shows on `irq` once `lockout` returns to 0.
- R9: When several active channels request at once, the lowest channel number is served first, and at most one `ack` bit is high in any cycle.
- R10: Requests from a channel that was never activated, or that a deactivate command has stopped, get no `ack` and cause no stall.
- R11: The in-memory count and address of channel n are accessed at `CW_BASE + 2n` and `CW_BASE + 2n + 1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_valid | input | 1 | Activate command strobe |
| act_ch | input | 3 | Channel to activate |
| act_cnt | input | 24 | Initial count for a fast count register |
| act_adr | input | 16 | Initial address for a fast address register |
| deact_valid | input | 1 | Deactivate command strobe |
| deact_ch | input | 3 | Channel to deactivate |
| lockout | input | 1 | Masks the interrupt outputs |
| req | input | 8 | Per-channel transfer request |
| ack | output | 8 | Per-channel data-cycle acknowledge |
| in_data | input | 96 | Input channel words, channel k in bits 24k+23:24k |
| out_data | output | 24 | Word for the acknowledged output channel |
| stall | output | 1 | Holds the processor off its next instruction |
| mem_req | output | 1 | Memory cycle in use by the engine |
| mem_we | output | 1 | Write at the clock edge that ends the cycle |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 24 | Memory write data |
| mem_rdata | input | 24 | Memory read data, combinational from `mem_addr` |
| irq | output | 8 | Per-channel completion interrupt |

## Verification
A request raised before clock edge p is granted at p. The stall then covers the 1, 2 or 3 cycles that follow p, and `ack` and `out_data` appear in the last of those cycles. Interrupt and deactivation take effect at the edge that ends that last cycle. The bench samples every result on the falling edge. It counts stalled falling edges until the first falling edge without a stall, records `ack`/`out_data` on the falling edge where `ack` is seen, and reads memory and `irq` only after the sequence has returned to idle.

// File: rtl/bufio_pkg.sv
package bufio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CNT,
        ST_ADR,
        ST_DAT
    } seq_state_t;
endpackage

// File: rtl/bufio_prio_arb.sv
module bufio_prio_arb #(
    parameter int N  = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/bufio_ctl_bank.sv
module bufio_ctl_bank #(
    parameter int           NCH      = 8,
    parameter int           W        = 24,
    parameter int           AW       = 16,
    parameter logic [NCH-1:0] FAST_CNT = '0,
    parameter logic [NCH-1:0] FAST_ADR = '0,
    localparam int          IW       = $clog2(NCH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_en,
    input  logic [IW-1:0]            load_ch,
    input  logic [W-1:0]             load_cnt,
    input  logic [AW-1:0]            load_adr,
    input  logic                     step_en,
    input  logic [IW-1:0]            step_ch,
    output logic [NCH-1:0][W-1:0]    cnt_q,
    output logic [NCH-1:0][AW-1:0]   adr_q
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        if (FAST_CNT[i]) begin : g_fc
            logic [W-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    r <= '0;
                else if (load_en && load_ch == IW'(i))
                    r <= load_cnt;
                else if (step_en && step_ch == IW'(i))
                    r <= r - W'(1);
            end
            assign cnt_q[i] = r;
        end else begin : g_mc
            assign cnt_q[i] = '0;
        end
        if (FAST_ADR[i]) begin : g_fa
            logic [AW-1:0] r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    r <= '0;
                else if (load_en && load_ch == IW'(i))
                    r <= load_adr;
                else if (step_en && step_ch == IW'(i))
                    r <= r + AW'(1);
            end
            assign adr_q[i] = r;
        end else begin : g_ma
            assign adr_q[i] = '0;
        end
    end
endmodule

// File: rtl/bufio_steal.sv
module bufio_steal
    import bufio_pkg::*;
#(
    parameter int NIN  = 4,
    parameter int NOUT = 4,
    parameter int W    = 24,
    parameter int AW   = 16,
    parameter logic [AW-1:0] CW_BASE = 16'h0010,
    parameter logic [NIN+NOUT-1:0] FAST_CNT = 8'b0000_0011,
    parameter logic [NIN+NOUT-1:0] FAST_ADR = 8'b0001_0001,
    localparam int NCH = NIN + NOUT,
    localparam int IW  = $clog2(NCH),
    localparam int NIW = $clog2(NIN)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               act_valid,
    input  logic [IW-1:0]      act_ch,
    input  logic [W-1:0]       act_cnt,
    input  logic [AW-1:0]      act_adr,
    input  logic               deact_valid,
    input  logic [IW-1:0]      deact_ch,
    input  logic               lockout,
    input  logic [NCH-1:0]     req,
    output logic [NCH-1:0]     ack,
    input  logic [NIN*W-1:0]   in_data,
    output logic [W-1:0]       out_data,
    output logic               stall,
    output logic               mem_req,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [W-1:0]       mem_wdata,
    input  logic [W-1:0]       mem_rdata,
    output logic [NCH-1:0]     irq
);
    seq_state_t state, state_nx;
    logic [IW-1:0]  ch_q;
    logic [AW-1:0]  adr_hold;
    logic           zero_hold;
    logic [NCH-1:0] active, pend;
    logic           g_any;
    logic [IW-1:0]  g_idx;
    logic           done_now;
    logic [NIN-1:0][W-1:0]  in_arr;
    logic [NCH-1:0][W-1:0]  fcnt;
    logic [NCH-1:0][AW-1:0] fadr;
    logic [AW-1:0]  cw_addr;

    assign in_arr  = in_data;
    assign cw_addr = CW_BASE + AW'(2 * ch_q);

    bufio_prio_arb #(.N(NCH)) u_arb (
        .req (req & active & {NCH{state == ST_IDLE}}),
        .any (g_any),
        .idx (g_idx)
    );

    bufio_ctl_bank #(
        .NCH(NCH), .W(W), .AW(AW), .FAST_CNT(FAST_CNT), .FAST_ADR(FAST_ADR)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (act_valid),
        .load_ch  (act_ch),
        .load_cnt (act_cnt),
        .load_adr (act_adr),
        .step_en  (state == ST_DAT),
        .step_ch  (ch_q),
        .cnt_q    (fcnt),
        .adr_q    (fadr)
    );

    // next-state decision
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (g_any)
                         state_nx = !FAST_CNT[g_idx] ? ST_CNT :
                                    !FAST_ADR[g_idx] ? ST_ADR : ST_DAT;
            ST_CNT:  state_nx = !FAST_ADR[ch_q] ? ST_ADR : ST_DAT;
            ST_ADR:  state_nx = ST_DAT;
            ST_DAT:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign done_now = FAST_CNT[ch_q] ? (fcnt[ch_q] == W'(1)) : zero_hold;

    // sequence bookkeeping and channel status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ch_q      <= '0;
            adr_hold  <= '0;
            zero_hold <= 1'b0;
            active    <= '0;
            pend      <= '0;
        end else begin
            if (state == ST_IDLE && g_any) ch_q <= g_idx;
            if (state == ST_CNT) zero_hold <= (mem_rdata == W'(1));
            if (state == ST_ADR) adr_hold <= mem_rdata[AW-1:0];
            if (deact_valid) active[deact_ch] <= 1'b0;
            if (act_valid) begin
                active[act_ch] <= 1'b1;
                pend[act_ch]   <= 1'b0;
            end
            if (state == ST_DAT && done_now) begin
                active[ch_q] <= 1'b0;
                pend[ch_q]   <= 1'b1;
            end
        end
    end

    // outputs per state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        ack       = '0;
        out_data  = '0;
        stall     = (state != ST_IDLE);
        unique case (state)
            ST_IDLE: ;
            ST_CNT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cw_addr;
                mem_wdata = mem_rdata - W'(1);
            end
            ST_ADR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cw_addr + AW'(1);
                mem_wdata = mem_rdata + W'(1);
            end
            ST_DAT: begin
                mem_req   = 1'b1;
                mem_addr  = FAST_ADR[ch_q] ? fadr[ch_q] : adr_hold;
                ack[ch_q] = 1'b1;
                if (32'(ch_q) < NIN) begin
                    mem_we    = 1'b1;
                    mem_wdata = in_arr[NIW'(ch_q)];
                end else begin
                    out_data  = mem_rdata;
                end
            end
        endcase
    end

    assign irq = pend & {NCH{~lockout}};

    // run length of the current stall, for the bound check
    logic [2:0] stall_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             stall_run <= '0;
        else if (!stall)        stall_run <= '0;
        else if (stall_run != 3'd7) stall_run <= stall_run + 3'd1;
    end

    a_r9_one_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack));
    a_r4_ack_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack) |-> stall);
    a_r2_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        stall_run <= 3'd3);
    a_r5_input_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (|ack[NIN-1:0]) |-> (mem_we && mem_req));
    for (genvar i = 0; i < NCH; i++) begin : g_chk
        a_r10_ack_active: assert property (@(posedge clk) disable iff (!rst_n)
            ack[i] |-> active[i]);
    end
endmodule

// File: tb/test_bufio_steal.sv
`timescale 1ns/1ps
module test_bufio_steal;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        act_valid = 1'b0;
    logic [2:0]  act_ch = '0;
    logic [23:0] act_cnt = '0;
    logic [15:0] act_adr = '0;
    logic        deact_valid = 1'b0;
    logic [2:0]  deact_ch = '0;
    logic        lockout = 1'b0;
    logic [7:0]  req = '0;
    logic [7:0]  ack;
    logic [95:0] in_data = '0;
    logic [23:0] out_data;
    logic        stall, mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [23:0] mem_wdata, mem_rdata;
    logic [7:0]  irq;
    logic [23:0] mem [256];
    int total = 0, bad = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    bufio_steal i_bufio_steal (
        .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_ch(act_ch),
        .act_cnt(act_cnt), .act_adr(act_adr), .deact_valid(deact_valid),
        .deact_ch(deact_ch), .lockout(lockout), .req(req), .ack(ack),
        .in_data(in_data), .out_data(out_data), .stall(stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic activate(input int ch, input logic [23:0] c, input logic [15:0] a);
        @(negedge clk);
        act_valid = 1'b1; act_ch = 3'(ch); act_cnt = c; act_adr = a;
        @(negedge clk);
        act_valid = 1'b0;
    endtask

    task automatic xfer(input int ch, input logic [23:0] din, output int nst,
                        output logic acked, output logic [23:0] dout);
        @(negedge clk);
        if (ch < 4) in_data[ch*24 +: 24] = din;
        req[ch] = 1'b1;
        nst = 0; acked = 1'b0; dout = '0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (stall) nst++;
            if (ack[ch]) begin
                acked = 1'b1; dout = out_data; req[ch] = 1'b0;
            end else if (acked && !stall) break;
        end
        req[ch] = 1'b0;
    endtask

    task automatic t_reset;
        chk(!stall && ack == 0 && irq == 0 && !mem_req, "R1 reset outputs",
            {stall, mem_req, ack, irq}, 0);
    endtask

    task automatic t_three;
        int n; logic a; logic [23:0] d;
        mem[8'h14] = 24'd3; mem[8'h15] = 24'h40;
        activate(2, 24'd99, 16'h9999);
        xfer(2, 24'hA1, n, a, d);
        chk(n == 3, "R2 stall cycles both in memory", n, 3);
        chk(mem[8'h40] == 24'hA1, "R5 first input word", mem[8'h40], 24'hA1);
        chk(mem[8'h14] == 24'd2, "R11 R2 count write-back", mem[8'h14], 2);
        chk(mem[8'h15] == 24'h41, "R11 R2 address write-back", mem[8'h15], 24'h41);
        xfer(2, 24'hA2, n, a, d);
        chk(mem[8'h41] == 24'hA2, "R5 consecutive address", mem[8'h41], 24'hA2);
        chk(irq[2] == 1'b0, "R7 no irq before zero", irq, 0);
        xfer(2, 24'hA3, n, a, d);
        chk(a && mem[8'h42] == 24'hA3, "R7 last word still moved", mem[8'h42], 24'hA3);
        chk(irq[2] == 1'b1, "R7 irq on zero", irq, 8'h04);
        xfer(2, 24'hA4, n, a, d);
        chk(!a && n == 0, "R7 channel deactivated", {a, n[7:0]}, 0);
        activate(2, 24'd0, 16'h0);
        chk(irq[2] == 1'b0, "R7 reactivate clears irq", irq, 0);
        @(negedge clk); deact_valid = 1'b1; deact_ch = 3'd2;
        @(negedge clk); deact_valid = 1'b0;
    endtask

    task automatic t_one;
        int n; logic a; logic [23:0] d;
        activate(0, 24'd2, 16'h50);
        xfer(0, 24'hB1, n, a, d);
        chk(n == 1, "R4 stall cycles both fast", n, 1);
        chk(mem[8'h50] == 24'hB1, "R4 R5 fast-address data", mem[8'h50], 24'hB1);
        lockout = 1'b1;
        xfer(0, 24'hB2, n, a, d);
        chk(mem[8'h51] == 24'hB2, "R5 fast address incremented", mem[8'h51], 24'hB2);
        chk(irq == 0, "R8 irq masked by lockout", irq, 0);
        @(negedge clk); lockout = 1'b0;
        @(negedge clk);
        chk(irq[0] == 1'b1, "R8 irq after lockout release", irq, 1);
    endtask

    task automatic t_two;
        int n; logic a; logic [23:0] d;
        mem[8'h13] = 24'h60;
        activate(1, 24'd5, 16'h0);
        xfer(1, 24'hC1, n, a, d);
        chk(n == 2, "R3 stall cycles address in memory", n, 2);
        chk(mem[8'h60] == 24'hC1 && mem[8'h13] == 24'h61, "R3 data and address update",
            mem[8'h13], 24'h61);
        mem[8'h18] = 24'd1; mem[8'h70] = 24'hBEEF01;
        activate(4, 24'd0, 16'h70);
        xfer(4, 24'h0, n, a, d);
        chk(n == 2, "R3 stall cycles count in memory", n, 2);
        chk(a && d == 24'hBEEF01, "R6 output word", d, 24'hBEEF01);
        chk(mem[8'h18] == 24'd0 && irq[4], "R7 R11 output completion", {mem[8'h18][7:0], irq}, 16'h0010);
    endtask

    task automatic t_prio;
        int first = -1; int nack = 0; logic multi = 1'b0;
        mem[8'h16] = 24'd4; mem[8'h17] = 24'h90;
        mem[8'h1A] = 24'd4; mem[8'h1B] = 24'hA0; mem[8'hA0] = 24'h5A5A5A;
        activate(3, 24'd0, 16'h0);
        activate(5, 24'd0, 16'h0);
        @(negedge clk);
        in_data[3*24 +: 24] = 24'hD3;
        req[3] = 1'b1; req[5] = 1'b1;
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            if ($countones(ack) > 1) multi = 1'b1;
            if (ack[3] || ack[5]) begin
                if (first < 0) first = ack[3] ? 3 : 5;
                nack++;
                if (ack[3]) req[3] = 1'b0;
                if (ack[5]) req[5] = 1'b0;
            end
        end
        chk(first == 3, "R9 lower channel first", first, 3);
        chk(nack == 2 && !multi, "R9 one ack at a time, both served", nack, 2);
    endtask

    task automatic t_deact;
        int n; logic a; logic [23:0] d;
        xfer(7, 24'h0, n, a, d);
        chk(!a && n == 0, "R10 never-activated channel ignored", {a, n[7:0]}, 0);
        mem[8'h1C] = 24'd4; mem[8'h1D] = 24'hB0;
        activate(6, 24'd0, 16'h0);
        @(negedge clk); deact_valid = 1'b1; deact_ch = 3'd6;
        @(negedge clk); deact_valid = 1'b0;
        xfer(6, 24'h0, n, a, d);
        chk(!a && n == 0 && mem[8'h1C] == 24'd4, "R10 deactivated channel ignored",
            mem[8'h1C], 4);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_three;
        t_one;
        t_two;
        t_prio;
        t_deact;
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule